// File: doc/BRIEF.md
# Serial Link Transaction and Break Sequencer

This block is the control engine for a single two-wire serial link to a remote slave. A host hands it one request at a time: a transfer, a terminate or a link break. For transfers and terminates it starts a separate frame transmitter and then a separate response receiver, and it acts on the response tag the receiver returns. A busy tag makes it clock the idle line for a fixed span and then send a data-poll command. The number of polls has a hard ceiling. Past that ceiling it sends a terminate command and reports the slave as stuck. Every tagged response is followed by a fixed run of priming clocks so the slave is ready for the next operation.

The block also runs the link break. This is a three-phase pattern of clocks with the data line high, then low, then high again, each phase with a fixed length. It runs the power-on clock-out with every pin control driven high. An external-mode input hands the pins to a different master. In that mode the pin drivers are released and every request is answered with a rejection. Leaving external mode runs the clock-out again before any new request is taken. Frame encoding and checksums are not done here; they belong to the transmitter and receiver.

Top module: `link_txn_seq`

## Requirements
- R1: While reset is applied and for INIT_CLKS (5000) cycles after it, the block drives the link clock with data high and with mux_sel, xlat_en and link_en all 1. req_ready stays 0 during this time.
- R2: req_ready drops in the cycle after a request is accepted. It stays 0 until the single resp_valid pulse for that request, and there is exactly one response per accepted request.
- R3: A transfer request (req_kind 0) pulses tx_start once with tx_cmd 0 (host frame). A terminate request (req_kind 1) pulses it with tx_cmd 2. rx_start pulses in the cycle after tx_done is seen.
- R4: A response with tag 0 (acknowledge) and no receiver fault gives resp_code 0, after a run of PRIME_CLKS (100) idle clocks with data high.
- R5: A response with tag 1 (busy) is followed by POLL_GAP (100) idle clocks with data high. A data-poll command (tx_cmd 1) is then sent, and the receiver is started again.
- R6: At most MAX_BUSY (100) data polls are sent per request. A busy tag after the last poll is followed by the idle gap and then a terminate command (tx_cmd 2). If that terminate is acknowledged, the response is resp_code 1 (stuck busy), after the priming run.
- R7: If the escalation terminate is not acknowledged, the link is reported lost with resp_code 2, after the priming run.
- R8: Tag 2 gives resp_code 2 (general error) and tag 3 gives resp_code 3 (slave saw a checksum error), each after the priming run.
- R9: A nonzero rx_fault (4 = receiver timeout, 5 = bad response checksum) is reported as resp_code equal to that value, with no priming clocks.
- R10: A break request (req_kind 2) drives BRK_PRE (50) clocks with data high, then BRK_LOW (256) clocks with data low, then BRK_POST (16000) clocks with data high, and then answers resp_code 0.
- R11: While ext_mode is 1 and the block is idle, pins_hiz is 1, mux_sel and xlat_en are 0, and no link clock runs. A request is answered with resp_code 6 (rejected) and starts neither the transmitter nor the receiver.
- R12: When ext_mode returns to 0, the R1 clock-out of INIT_CLKS cycles runs again with req_ready 0, before any request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 hands the link pins to another master |
| req_valid | input | 1 | Host request present |
| req_kind | input | 2 | 0 transfer, 1 terminate, 2 break |
| req_slave | input | 2 | Target slave id |
| req_ready | output | 1 | Request can be accepted this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_code | output | 3 | 0 ok, 1 stuck busy, 2 general/lost, 3 slave checksum, 4 timeout, 5 master checksum, 6 rejected |
| tx_start | output | 1 | Starts the frame transmitter |
| tx_cmd | output | 2 | 0 host frame, 1 data poll, 2 terminate |
| tx_slave | output | 2 | Slave id for the transmitter |
| tx_done | input | 1 | Transmitter finished |
| rx_start | output | 1 | Starts the response receiver |
| rx_done | input | 1 | Receiver finished, tag and fault valid |
| rx_tag | input | 2 | 0 ack, 1 busy, 2 error, 3 checksum error at slave |
| rx_fault | input | 3 | 0 none, 4 timeout, 5 bad checksum |
| seq_clk_en | output | 1 | Sequencer drives one link clock per cycle |
| seq_dat | output | 1 | Data level driven with those clocks |
| pins_hiz | output | 1 | Clock and data pins released |
| mux_sel | output | 1 | Pin multiplexer select |
| xlat_en | output | 1 | Level translator direction enable |
| link_en | output | 1 | Link enable |

## Verification
The hardest state to reach is the retry ceiling. The slave has to answer busy on every one of a hundred polls and once more, and only then does the terminate escalation appear. A second variant is needed where the terminate itself gets no acknowledge. The bench's receiver stand-in replays a queue of tags. Those scripts preload 101 busy tags followed by either an acknowledge or another busy. The bench then checks the full sequence of commands and every idle run against the expected list. The break's 16000-cycle final phase and the clock-out after leaving external mode are measured as exact run lengths by a monitor that records every contiguous idle-clock span.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

    typedef enum logic [3:0] {
        ST_INIT, ST_IDLE, ST_EXT, ST_REJ, ST_SEND, ST_WTX, ST_RECV, ST_WRX,
        ST_GAP, ST_PRIME, ST_BPRE, ST_BLOW, ST_BPOST, ST_RESP
    } seq_st_t;

    typedef enum logic [1:0] {
        CMD_FRAME = 2'd0,
        CMD_POLL  = 2'd1,
        CMD_TERM  = 2'd2
    } tx_cmd_t;

    localparam logic [1:0] KIND_XFER  = 2'd0;
    localparam logic [1:0] KIND_TERM  = 2'd1;
    localparam logic [1:0] KIND_BREAK = 2'd2;

    localparam logic [1:0] TAG_ACK  = 2'd0;
    localparam logic [1:0] TAG_BUSY = 2'd1;
    localparam logic [1:0] TAG_ERRA = 2'd2;
    localparam logic [1:0] TAG_ERRC = 2'd3;

    localparam logic [2:0] RC_OK    = 3'd0;
    localparam logic [2:0] RC_STUCK = 3'd1;
    localparam logic [2:0] RC_GEN   = 3'd2;
    localparam logic [2:0] RC_SCRC  = 3'd3;
    localparam logic [2:0] RC_REJ   = 3'd6;

    typedef struct packed {
        logic clk_en;
        logic dat;
        logic hiz;
        logic mux;
        logic xlat;
    } pin_ctl_t;

    // Result code for a non-busy tag; escalated marks the stuck-slave terminate.
    function automatic logic [2:0] tag_result(input logic [1:0] tag, input logic escalated);
        if (escalated)
            return (tag == TAG_ACK) ? RC_STUCK : RC_GEN;
        case (tag)
            TAG_ERRA: return RC_GEN;
            TAG_ERRC: return RC_SCRC;
            default:  return RC_OK;
        endcase
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lnk_span_timer.sv
module lnk_span_timer #(
    parameter int W       = 15,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lnk_retry_ctr.sv
module lnk_retry_ctr #(
    parameter int MAX_BUSY = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);
    localparam int RW = $clog2(MAX_BUSY + 1);
    logic [RW-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst || clr)
            polls <= '0;
        else if (inc)
            polls <= polls + 1'b1;
    end

    assign at_cap = (polls >= RW'(MAX_BUSY));
endmodule

// File: rtl/lnk_pin_map.sv
module lnk_pin_map
    import link_seq_pkg::*;
(
    input  seq_st_t  st,
    output pin_ctl_t pins
);
    always_comb begin
        pins = '{clk_en: 1'b0, dat: 1'b1, hiz: 1'b0, mux: 1'b1, xlat: 1'b1};
        case (st)
            ST_INIT, ST_GAP, ST_PRIME, ST_BPRE, ST_BPOST: pins.clk_en = 1'b1;
            ST_BLOW: begin
                pins.clk_en = 1'b1;
                pins.dat    = 1'b0;
            end
            ST_EXT, ST_REJ: begin
                pins.hiz  = 1'b1;
                pins.mux  = 1'b0;
                pins.xlat = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/link_txn_seq.sv
module link_txn_seq
    import link_seq_pkg::*;
#(
    parameter int INIT_CLKS = 5000,
    parameter int POLL_GAP  = 100,
    parameter int PRIME_CLKS = 100,
    parameter int MAX_BUSY  = 100,
    parameter int BRK_PRE   = 50,
    parameter int BRK_LOW   = 256,
    parameter int BRK_POST  = 16000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    input  logic [1:0] req_slave,
    output logic       req_ready,
    output logic       resp_valid,
    output logic [2:0] resp_code,
    output logic       tx_start,
    output logic [1:0] tx_cmd,
    output logic [1:0] tx_slave,
    input  logic       tx_done,
    output logic       rx_start,
    input  logic       rx_done,
    input  logic [1:0] rx_tag,
    input  logic [2:0] rx_fault,
    output logic       seq_clk_en,
    output logic       seq_dat,
    output logic       pins_hiz,
    output logic       mux_sel,
    output logic       xlat_en,
    output logic       link_en
);
    localparam int MAXC = max_of(max_of(max_of(INIT_CLKS, POLL_GAP), max_of(PRIME_CLKS, BRK_PRE)),
                                 max_of(BRK_LOW, BRK_POST));
    localparam int CW = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] LD_INIT  = CW'(INIT_CLKS - 1);
    localparam logic [CW-1:0] LD_GAP   = CW'(POLL_GAP - 1);
    localparam logic [CW-1:0] LD_PRIME = CW'(PRIME_CLKS - 1);
    localparam logic [CW-1:0] LD_BPRE  = CW'(BRK_PRE - 1);
    localparam logic [CW-1:0] LD_BLOW  = CW'(BRK_LOW - 1);
    localparam logic [CW-1:0] LD_BPOST = CW'(BRK_POST - 1);

    seq_st_t    st, nxt;
    tx_cmd_t    cmd_q, cmd_d;
    logic       esc_q, esc_d;
    logic [2:0] code_q, code_d;
    logic [1:0] slave_q, slave_d;
    logic       t_load, t_zero, r_clr, r_inc, r_cap;
    logic [CW-1:0] t_val;
    pin_ctl_t   pins;

    lnk_span_timer #(.W(CW), .RST_VAL(INIT_CLKS - 1)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
    );

    lnk_retry_ctr #(.MAX_BUSY(MAX_BUSY)) u_retry (
        .clk(clk), .rst(rst), .clr(r_clr), .inc(r_inc), .at_cap(r_cap)
    );

    lnk_pin_map u_pins (.st(st), .pins(pins));

    always_comb begin
        nxt     = st;
        cmd_d   = cmd_q;
        esc_d   = esc_q;
        code_d  = code_q;
        slave_d = slave_q;
        t_load  = 1'b0;
        t_val   = '0;
        r_clr   = 1'b0;
        r_inc   = 1'b0;
        case (st)
            ST_INIT: if (t_zero) nxt = ST_IDLE;
            ST_IDLE: begin
                if (ext_mode) begin
                    nxt = ST_EXT;
                end else if (req_valid) begin
                    slave_d = req_slave;
                    esc_d   = 1'b0;
                    r_clr   = 1'b1;
                    if (req_kind == KIND_BREAK) begin
                        nxt    = ST_BPRE;
                        t_load = 1'b1;
                        t_val  = LD_BPRE;
                    end else begin
                        nxt   = ST_SEND;
                        cmd_d = (req_kind == KIND_TERM) ? CMD_TERM : CMD_FRAME;
                    end
                end
            end
            ST_EXT: begin
                if (!ext_mode) begin
                    nxt    = ST_INIT;
                    t_load = 1'b1;
                    t_val  = LD_INIT;
                end else if (req_valid) begin
                    nxt    = ST_REJ;
                    code_d = RC_REJ;
                end
            end
            ST_REJ:  nxt = ST_EXT;
            ST_SEND: nxt = ST_WTX;
            ST_WTX:  if (tx_done) nxt = ST_RECV;
            ST_RECV: nxt = ST_WRX;
            ST_WRX: begin
                if (rx_done) begin
                    if (rx_fault != 3'd0) begin
                        code_d = rx_fault;
                        nxt    = ST_RESP;
                    end else if (rx_tag == TAG_BUSY && !esc_q) begin
                        nxt    = ST_GAP;
                        t_load = 1'b1;
                        t_val  = LD_GAP;
                    end else begin
                        code_d = tag_result(rx_tag, esc_q);
                        nxt    = ST_PRIME;
                        t_load = 1'b1;
                        t_val  = LD_PRIME;
                    end
                end
            end
            ST_GAP: begin
                if (t_zero) begin
                    nxt = ST_SEND;
                    if (r_cap) begin
                        cmd_d = CMD_TERM;
                        esc_d = 1'b1;
                    end else begin
                        cmd_d = CMD_POLL;
                        r_inc = 1'b1;
                    end
                end
            end
            ST_PRIME: if (t_zero) nxt = ST_RESP;
            ST_BPRE: begin
                if (t_zero) begin
                    nxt    = ST_BLOW;
                    t_load = 1'b1;
                    t_val  = LD_BLOW;
                end
            end
            ST_BLOW: begin
                if (t_zero) begin
                    nxt    = ST_BPOST;
                    t_load = 1'b1;
                    t_val  = LD_BPOST;
                end
            end
            ST_BPOST: begin
                if (t_zero) begin
                    nxt    = ST_RESP;
                    code_d = RC_OK;
                end
            end
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_INIT;
            cmd_q   <= CMD_FRAME;
            esc_q   <= 1'b0;
            code_q  <= RC_OK;
            slave_q <= '0;
        end else begin
            st      <= nxt;
            cmd_q   <= cmd_d;
            esc_q   <= esc_d;
            code_q  <= code_d;
            slave_q <= slave_d;
        end
    end

    assign req_ready  = (st == ST_IDLE && !ext_mode) || (st == ST_EXT && ext_mode);
    assign resp_valid = (st == ST_RESP) || (st == ST_REJ);
    assign resp_code  = code_q;
    assign tx_start   = (st == ST_SEND);
    assign tx_cmd     = cmd_q;
    assign tx_slave   = slave_q;
    assign rx_start   = (st == ST_RECV);
    assign seq_clk_en = pins.clk_en;
    assign seq_dat    = pins.dat;
    assign pins_hiz   = pins.hiz;
    assign mux_sel    = pins.mux;
    assign xlat_en    = pins.xlat;
    assign link_en    = 1'b1;
endmodule

// File: rtl/link_txn_seq_chk.sv
module link_txn_seq_chk #(
    parameter int MAX_BUSY = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       resp_valid,
    input logic       tx_start,
    input logic [1:0] tx_cmd,
    input logic       tx_done,
    input logic       rx_start,
    input logic       seq_clk_en,
    input logic       seq_dat,
    input logic       pins_hiz,
    input logic       mux_sel,
    input logic       xlat_en
);
    localparam int PW = $clog2(MAX_BUSY + 2) + 1;
    logic [PW-1:0] polls_seen;

    always_ff @(posedge clk) begin
        if (rst || (req_valid && req_ready))
            polls_seen <= '0;
        else if (tx_start && tx_cmd == 2'd1)
            polls_seen <= polls_seen + 1'b1;
    end

    p_init_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !pins_hiz |-> (mux_sel && xlat_en));

    p_no_ready_at_resp_r2: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);

    p_tx_single_r3: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    p_rx_after_tx_r3: assert property (@(posedge clk) disable iff (rst)
        rx_start |-> $past(tx_done));

    p_gap_before_poll_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_cmd == 2'd1) |-> ($past(seq_clk_en) && $past(seq_dat)));

    p_poll_cap_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_start && tx_cmd == 2'd1) |-> (polls_seen < PW'(MAX_BUSY)));

    p_break_low_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (seq_clk_en && !seq_dat) |-> !req_ready);

    p_ext_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        pins_hiz |-> (!tx_start && !rx_start && !seq_clk_en && !mux_sel && !xlat_en));
endmodule

bind link_txn_seq link_txn_seq_chk #(.MAX_BUSY(MAX_BUSY)) u_chk (.*);

// File: tb/sim_link_txn_seq.sv
`timescale 1ns/1ps
module sim_link_txn_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] req_slave = 2'd0;
    logic       req_ready, resp_valid;
    logic [2:0] resp_code;
    logic       tx_start, rx_start;
    logic [1:0] tx_cmd, tx_slave;
    logic       tx_done = 1'b0;
    logic       rx_done = 1'b0;
    logic [1:0] rx_tag = 2'd0;
    logic [2:0] rx_fault = 3'd0;
    logic       seq_clk_en, seq_dat, pins_hiz, mux_sel, xlat_en, link_en;

    always #5 clk = ~clk;

    link_txn_seq u0 (
        .clk(clk), .rst(rst), .ext_mode(ext_mode),
        .req_valid(req_valid), .req_kind(req_kind), .req_slave(req_slave),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_code(resp_code),
        .tx_start(tx_start), .tx_cmd(tx_cmd), .tx_slave(tx_slave), .tx_done(tx_done),
        .rx_start(rx_start), .rx_done(rx_done), .rx_tag(rx_tag), .rx_fault(rx_fault),
        .seq_clk_en(seq_clk_en), .seq_dat(seq_dat), .pins_hiz(pins_hiz),
        .mux_sel(mux_sel), .xlat_en(xlat_en), .link_en(link_en)
    );

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    int run_lvl[$];
    int run_len[$];
    int cmds[$];
    int tag_q[$];
    int fault_q[$];
    int cur_lvl = 0;
    int cur_len = 0;
    bit waiting = 0;
    int stray = 0;
    int tx_wait = -1;
    int rx_wait = -1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: samples outputs mid-cycle on every clock.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (seq_clk_en) begin
                if (cur_len > 0 && int'(seq_dat) == cur_lvl) cur_len++;
                else begin
                    if (cur_len > 0) begin run_lvl.push_back(cur_lvl); run_len.push_back(cur_len); end
                    cur_lvl = int'(seq_dat);
                    cur_len = 1;
                end
            end else if (cur_len > 0) begin
                run_lvl.push_back(cur_lvl); run_len.push_back(cur_len);
                cur_len = 0;
            end
            if (tx_start) cmds.push_back(int'(tx_cmd));
            if (resp_valid && !waiting) stray++;
        end
    end

    // Transmitter and receiver stand-ins.
    always @(negedge clk) begin
        tx_done <= 1'b0;
        rx_done <= 1'b0;
        if (tx_wait == 0) tx_done <= 1'b1;
        if (tx_wait >= 0) tx_wait = tx_wait - 1;
        if (rx_wait == 0) begin
            rx_done  <= 1'b1;
            rx_tag   <= (tag_q.size() > 0) ? 2'(tag_q.pop_front()) : 2'd0;
            rx_fault <= (fault_q.size() > 0) ? 3'(fault_q.pop_front()) : 3'd0;
        end
        if (rx_wait >= 0) rx_wait = rx_wait - 1;
        if (tx_start) tx_wait = 3;
        if (rx_start) rx_wait = 2;
    end

    task automatic clear_obs();
        run_lvl.delete(); run_len.delete(); cmds.delete();
    endtask

    task automatic do_req(input logic [1:0] kind, input string req, output int code);
        bit ready_bad = 0;
        @(negedge clk);
        clear_obs();
        req_valid = 1'b1; req_kind = kind; req_slave = 2'd2;
        while (!req_ready) @(negedge clk);
        waiting = 1;
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        while (!resp_valid) begin
            if (req_ready) ready_bad = 1;
            @(negedge clk); #2;
        end
        code = int'(resp_code);
        chk({req, " ready low in flight R2"}, int'(ready_bad), 0);
        @(negedge clk); #2;
        chk({req, " single response R2"}, int'(resp_valid), 0);
        waiting = 0;
    endtask

    task automatic check_runs100(input string req, input int n);
        int bad = 0;
        chk({req, " run count"}, run_lvl.size(), n);
        foreach (run_len[i]) if (run_len[i] != 100 || run_lvl[i] != 1) bad++;
        chk({req, " runs of 100 high"}, bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!reported) begin
            reported = 1;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
            finish_run();
        end
    end

    initial begin
        int code;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mux at reset", int'(mux_sel), 1);
        chk("R1 xlat at reset", int'(xlat_en), 1);
        chk("R1 enable at reset", int'(link_en), 1);
        chk("R1 ready low in reset", int'(req_ready), 0);
        rst = 1'b0;
        repeat (2500) @(negedge clk);
        #2;
        chk("R1 ready low during clock-out", int'(req_ready), 0);
        chk("R1 data high during clock-out", int'(seq_dat), 1);
        while (!req_ready) @(negedge clk);
        #2;
        chk("R1 clock-out run count", run_len.size(), 1);
        chk("R1 clock-out length", (run_len.size() > 0) ? run_len[0] : -1, 5000);

        // R3 R4: plain transfer acknowledged
        do_req(2'd0, "R4 ack", code);
        chk("R4 code", code, 0);
        chk("R3 frame cmd", (cmds.size() == 1) ? cmds[0] : -1, 0);
        check_runs100("R4 prime", 1);

        // R3: terminate request
        do_req(2'd1, "R3 term", code);
        chk("R3 term cmd", (cmds.size() == 1) ? cmds[0] : -1, 2);
        chk("R3 term code", code, 0);

        // R5: two busy then ack
        tag_q = '{1, 1, 0};
        do_req(2'd0, "R5 busy", code);
        chk("R5 code", code, 0);
        chk("R5 cmd count", cmds.size(), 3);
        chk("R5 poll cmds", (cmds.size() == 3) ? cmds[1] * 10 + cmds[2] : -1, 11);
        check_runs100("R5 gaps", 3);

        // R8: error tags
        tag_q = '{2};
        do_req(2'd0, "R8 errA", code);
        chk("R8 errA code", code, 2);
        check_runs100("R8 errA prime", 1);
        tag_q = '{3};
        do_req(2'd0, "R8 errC", code);
        chk("R8 errC code", code, 3);

        // R9: receiver faults skip priming
        fault_q = '{4};
        do_req(2'd0, "R9 timeout", code);
        chk("R9 timeout code", code, 4);
        chk("R9 no prime", run_len.size(), 0);
        fault_q = '{5};
        do_req(2'd0, "R9 crc", code);
        chk("R9 crc code", code, 5);

        // R6: stuck slave, terminate acked
        tag_q.delete();
        for (int i = 0; i < 101; i++) tag_q.push_back(1);
        tag_q.push_back(0);
        do_req(2'd0, "R6 stuck", code);
        chk("R6 code", code, 1);
        chk("R6 cmd count", cmds.size(), 102);
        begin
            int polls = 0;
            foreach (cmds[i]) if (cmds[i] == 1) polls++;
            chk("R6 poll count", polls, 100);
        end
        chk("R6 last cmd term", (cmds.size() > 0) ? cmds[cmds.size()-1] : -1, 2);
        check_runs100("R6 runs", 102);

        // R7: terminate not acknowledged
        tag_q.delete();
        for (int i = 0; i < 102; i++) tag_q.push_back(1);
        do_req(2'd0, "R7 lost", code);
        chk("R7 code", code, 2);

        // R10: break
        do_req(2'd2, "R10 break", code);
        chk("R10 code", code, 0);
        chk("R10 phases", run_len.size(), 3);
        if (run_len.size() == 3) begin
            chk("R10 pre", run_len[0] * 2 + run_lvl[0], 101);
            chk("R10 low", run_len[1] * 2 + run_lvl[1], 512);
            chk("R10 post", run_len[2] * 2 + run_lvl[2], 32001);
        end
        chk("R10 no tx", cmds.size(), 0);

        // R11: external mode
        @(negedge clk);
        ext_mode = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk("R11 hiz", int'(pins_hiz), 1);
        chk("R11 mux", int'(mux_sel), 0);
        chk("R11 xlat", int'(xlat_en), 0);
        chk("R11 no clock", int'(seq_clk_en), 0);
        do_req(2'd0, "R11 reject", code);
        chk("R11 code", code, 6);
        chk("R11 no tx", cmds.size(), 0);

        // R12: leaving external mode reruns clock-out
        @(negedge clk);
        clear_obs();
        ext_mode = 1'b0;
        req_valid = 1'b1; req_kind = 2'd0;
        repeat (100) @(negedge clk);
        #2;
        chk("R12 ready low", int'(req_ready), 0);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        #2;
        chk("R12 clock-out length", (run_len.size() == 1) ? run_len[0] : -1, 5000);
        chk("R12 no tx during clock-out", cmds.size(), 0);
        do_req(2'd0, "R12 after", code);
        chk("R12 ok after", code, 0);

        chk("R2 no stray responses", stray, 0);
        if (!reported) begin
            reported = 1;
            finish_run();
        end
    end
endmodule